// File: doc/BRIEF.md
# Partitioned SIMD adder-subtractor

This unit adds or subtracts two 64-bit fixed-point operands. Its carry chain can be cut at byte-aligned lane boundaries, so the same adder computes one 64-bit, two 32-bit, four 16-bit or eight 8-bit independent sums or differences in a single pass. Every lane reports its own carry and signed-overflow bit. Summary zero, overflow and carry flags cover the whole word.

The same datapath also performs bitwise AND, OR, XOR and AND-with-complement, either on the full 64-bit word or on the low 32-bit word only. Operands, operation and lane size are presented together with `in_valid`. The registered result and flags appear one clock later, qualified by `out_valid`, and they keep their values until the next accepted operation.

Top module: `simd_addsub`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly one clock. The result and flags of an operation accepted at a rising edge are visible at the outputs immediately after that edge.
- R2: While `in_valid` is low, `result`, `lane_carry`, `lane_ovf` and the three summary flags keep their previous values.
- R3: `lane_sel` chooses the lane width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. Lane k occupies result bits [k*W +: W]. No carry crosses from one lane into the next.
- R4: `op_sel` 0 adds (a + b) and `op_sel` 1 subtracts (a - b, formed as a + ~b + 1), lane by lane. In subtraction a lane's carry is 1 when no borrow occurs.
- R5: `lane_carry[k]` is the carry out of the most significant bit of lane k. Bits at positions equal to or above the number of active lanes are 0.
- R6: `lane_ovf[k]` is set when lane k's two's-complement result overflows: the effective operands have the same sign and the lane result has the other sign. Bits at positions equal to or above the number of active lanes are 0.
- R7: `flag_zero` is 1 exactly when the whole 64-bit `result` is zero, for every operation.
- R8: `flag_ovf` is the OR of all `lane_ovf` bits and `flag_carry` is the OR of all `lane_carry` bits.
- R9: `op_sel` 2 = AND, 3 = OR, 4 = XOR, 5 = a AND NOT b. With `lane_sel` 3 the operation covers all 64 bits. With any other `lane_sel` it covers bits [31:0] and result bits [63:32] are 0. Codes 6 and 7 give a zero result. For every code from 2 to 7, `lane_carry` and `lane_ovf` are 0.
- R10: During a synchronous active-low reset, `out_valid`, `result`, `lane_carry`, `lane_ovf` and all summary flags are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| op_sel | input | 3 | Operation code (R4, R9) |
| lane_sel | input | 2 | Lane width select (R3) |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 64 | Registered result |
| lane_carry | output | 8 | Per-lane carry out |
| lane_ovf | output | 8 | Per-lane signed overflow |
| flag_zero | output | 1 | Whole result is zero |
| flag_ovf | output | 1 | Any lane overflowed |
| flag_carry | output | 1 | Any lane carried out |

## Verification
Suppose a lane-start bit is decoded wrongly, or a slice takes its carry-in from the wrong source. A carry then leaks across a lane boundary, and the very next registered result shows it as a wrong low bit in the upper lane and a wrong flag in the lower lane. A flag gathered from the wrong slice shows up as a wrong `lane_carry` or `lane_ovf` bit, or as a nonzero bit at an inactive lane position, one cycle after the operands were accepted. Broken hold or valid logic shows as changed outputs or a stray `out_valid` on the first idle cycle. Operand patterns that put all-ones bytes next to lane boundaries, run at every lane width, make each such fault visible within one operation.

// File: rtl/simd_addsub_pkg.sv
// Package: shared sizes, operation codes and lane-size codes for the
// partitioned adder-subtractor. Assumes a datapath width that is a whole
// number of slices.
package simd_addsub_pkg;
    localparam int DATA_W  = 64;
    localparam int SLICE_W = 8;
    localparam int OP_W    = 3;
    localparam int LSEL_W  = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_ANDN = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [LSEL_W-1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_e;

    // True for the two codes that use the carry chain.
    function automatic logic op_is_arith(input op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction
endpackage

// File: rtl/simd_lane_map.sv
// Lane map: marks which slices start a new lane for the selected lane size.
// Assumes 8 slices or fewer per word. A lane spans 1, 2, 4 or 8 slices.
module simd_lane_map #(
    parameter int NUM_SLICES = 8,
    parameter int LSEL_W     = 2
) (
    input  logic [LSEL_W-1:0]     lane_sel,
    output logic [NUM_SLICES-1:0] slice_first
);
    genvar i;
    generate
        for (i = 0; i < NUM_SLICES; i++) begin : g_first
            localparam logic AT_16 = (i % 2) == 0;
            localparam logic AT_32 = (i % 4) == 0;
            localparam logic AT_64 = (i % 8) == 0;
            // Purpose: a slice starts a lane when its index is a multiple of the lane span.
            always_comb begin
                case (lane_sel)
                    2'd0:    slice_first[i] = 1'b1;
                    2'd1:    slice_first[i] = AT_16;
                    2'd2:    slice_first[i] = AT_32;
                    default: slice_first[i] = AT_64;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/simd_carry_chain.sv
// Carry chain: a ripple of slice adders. A slice that starts a lane takes
// the operation's carry-in (0 add, 1 subtract). Every other slice takes the
// carry out of the slice below it. Assumes subtraction inverts operand b.
module simd_carry_chain #(
    parameter int SLICE_W    = 8,
    parameter int NUM_SLICES = 8,
    localparam int DW        = SLICE_W * NUM_SLICES
) (
    input  logic [DW-1:0]         a,
    input  logic [DW-1:0]         b,
    input  logic                  sub,
    input  logic [NUM_SLICES-1:0] slice_first,
    output logic [DW-1:0]         sum,
    output logic [NUM_SLICES-1:0] slice_cout,
    output logic [NUM_SLICES-1:0] slice_ovf
);
    genvar i;
    generate
        for (i = 0; i < NUM_SLICES; i++) begin : g_slice
            logic [SLICE_W-1:0] a_s;
            logic [SLICE_W-1:0] b_eff;
            logic [SLICE_W:0]   tot;
            logic               chain_in;
            logic               cin;
            logic               cout;

            if (i == 0) begin : g_lsb
                assign chain_in = sub;
            end else begin : g_upper
                assign chain_in = g_slice[i-1].cout;
            end

            // Purpose: choose the carry-in and add this slice.
            always_comb begin
                a_s   = a[i*SLICE_W +: SLICE_W];
                b_eff = sub ? ~b[i*SLICE_W +: SLICE_W] : b[i*SLICE_W +: SLICE_W];
                cin   = slice_first[i] ? sub : chain_in;
                tot   = {1'b0, a_s} + {1'b0, b_eff} + {{SLICE_W{1'b0}}, cin};
            end

            assign cout                       = tot[SLICE_W];
            assign sum[i*SLICE_W +: SLICE_W]  = tot[SLICE_W-1:0];
            assign slice_cout[i]              = cout;
            assign slice_ovf[i]               = (a_s[SLICE_W-1] == b_eff[SLICE_W-1]) &&
                                                (tot[SLICE_W-1] != a_s[SLICE_W-1]);
        end
    endgenerate
endmodule

// File: rtl/simd_flag_gather.sv
// Flag gather: for each lane k, picks the carry and overflow of the slice
// at the top of that lane. Lanes beyond the active count report 0, and so
// does every lane when the operation is not arithmetic.
module simd_flag_gather #(
    parameter int NUM_SLICES = 8,
    parameter int LSEL_W     = 2
) (
    input  logic [LSEL_W-1:0]     lane_sel,
    input  logic                  arith,
    input  logic [NUM_SLICES-1:0] slice_cout,
    input  logic [NUM_SLICES-1:0] slice_ovf,
    output logic [NUM_SLICES-1:0] lane_c,
    output logic [NUM_SLICES-1:0] lane_v
);
    localparam int NSEL = 1 << LSEL_W;

    genvar k, s;
    generate
        for (k = 0; k < NUM_SLICES; k++) begin : g_lane
            logic [NSEL-1:0] cand_c;
            logic [NSEL-1:0] cand_v;
            for (s = 0; s < NSEL; s++) begin : g_size
                localparam int SPAN = 1 << s;
                if ((k + 1) * SPAN <= NUM_SLICES) begin : g_live
                    assign cand_c[s] = slice_cout[(k+1)*SPAN-1];
                    assign cand_v[s] = slice_ovf[(k+1)*SPAN-1];
                end else begin : g_dead
                    assign cand_c[s] = 1'b0;
                    assign cand_v[s] = 1'b0;
                end
            end
            // Purpose: select this lane's flags for the active lane size.
            always_comb begin
                lane_c[k] = arith & cand_c[lane_sel];
                lane_v[k] = arith & cand_v[lane_sel];
            end
        end
    endgenerate
endmodule

// File: rtl/simd_logic_unit.sv
// Logic unit: bitwise AND, OR, XOR and AND-with-complement. When the wide
// select is low, only the low half of the word is produced and the upper
// half is 0. Codes outside the logic set give 0.
module simd_logic_unit
    import simd_addsub_pkg::*;
#(
    parameter int DW  = 64,
    localparam int HALF = DW / 2
) (
    input  op_e           op,
    input  logic          wide,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    logic [DW-1:0] full;

    // Purpose: evaluate the bitwise function over the whole word.
    always_comb begin
        case (op)
            OP_AND:  full = a & b;
            OP_OR:   full = a | b;
            OP_XOR:  full = a ^ b;
            OP_ANDN: full = a & ~b;
            default: full = '0;
        endcase
    end

    // Purpose: clear the upper half for a narrow logic operation.
    always_comb begin
        y = wide ? full : {{HALF{1'b0}}, full[HALF-1:0]};
    end
endmodule

// File: rtl/simd_addsub.sv
// Top: the partitioned SIMD adder-subtractor with its logic path. Inputs
// are sampled when in_valid is high. The result and flags are registered
// and held until the next accepted operation. Assumes a synchronous
// active-low reset.
module simd_addsub
    import simd_addsub_pkg::*;
#(
    parameter int DW  = simd_addsub_pkg::DATA_W,
    parameter int SW  = simd_addsub_pkg::SLICE_W,
    localparam int NS = DW / SW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [DW-1:0]              opnd_a,
    input  logic [DW-1:0]              opnd_b,
    input  logic [OP_W-1:0]            op_sel,
    input  logic [LSEL_W-1:0]          lane_sel,
    output logic                       out_valid,
    output logic [DW-1:0]              result,
    output logic [NS-1:0]              lane_carry,
    output logic [NS-1:0]              lane_ovf,
    output logic                       flag_zero,
    output logic                       flag_ovf,
    output logic                       flag_carry
);
    op_e           op;
    logic          arith;
    logic          sub;
    logic [NS-1:0] slice_first;
    logic [DW-1:0] sum;
    logic [NS-1:0] slice_cout;
    logic [NS-1:0] slice_ovf;
    logic [NS-1:0] lane_c_d;
    logic [NS-1:0] lane_v_d;
    logic [DW-1:0] logic_y;
    logic [DW-1:0] res_d;

    assign op    = op_e'(op_sel);
    assign arith = op_is_arith(op);
    assign sub   = (op == OP_SUB);

    simd_lane_map #(.NUM_SLICES(NS), .LSEL_W(LSEL_W)) u_map (
        .lane_sel    (lane_sel),
        .slice_first (slice_first)
    );

    simd_carry_chain #(.SLICE_W(SW), .NUM_SLICES(NS)) u_chain (
        .a           (opnd_a),
        .b           (opnd_b),
        .sub         (sub),
        .slice_first (slice_first),
        .sum         (sum),
        .slice_cout  (slice_cout),
        .slice_ovf   (slice_ovf)
    );

    simd_flag_gather #(.NUM_SLICES(NS), .LSEL_W(LSEL_W)) u_gather (
        .lane_sel   (lane_sel),
        .arith      (arith),
        .slice_cout (slice_cout),
        .slice_ovf  (slice_ovf),
        .lane_c     (lane_c_d),
        .lane_v     (lane_v_d)
    );

    simd_logic_unit #(.DW(DW)) u_logic (
        .op   (op),
        .wide (lane_sel == LANE_64),
        .a    (opnd_a),
        .b    (opnd_b),
        .y    (logic_y)
    );

    // Purpose: choose the arithmetic or the logic result.
    always_comb begin
        res_d = arith ? sum : logic_y;
    end

    // Purpose: register the result and flags and track output validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            result     <= '0;
            lane_carry <= '0;
            lane_ovf   <= '0;
            flag_zero  <= 1'b0;
            flag_ovf   <= 1'b0;
            flag_carry <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result     <= res_d;
                lane_carry <= lane_c_d;
                lane_ovf   <= lane_v_d;
                flag_zero  <= (res_d == '0);
                flag_ovf   <= |lane_v_d;
                flag_carry <= |lane_c_d;
            end
        end
    end
endmodule

// File: rtl/simd_addsub_chk.sv
// Checker: temporal properties of the adder-subtractor's ports, attached
// to the top module by the bind statement at the end of this file.
module simd_addsub_chk #(
    parameter int DW = 64,
    parameter int NS = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] opnd_a,
    input logic [DW-1:0] opnd_b,
    input logic [2:0]    op_sel,
    input logic [1:0]    lane_sel,
    input logic          out_valid,
    input logic [DW-1:0] result,
    input logic [NS-1:0] lane_carry,
    input logic [NS-1:0] lane_ovf,
    input logic          flag_zero,
    input logic          flag_ovf,
    input logic          flag_carry
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid) |=> out_valid);

    a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !in_valid) |=> !out_valid);

    a_r2_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !in_valid) |=> ($stable(result) && $stable(lane_carry) && $stable(lane_ovf)));

    a_r3_add64_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd0 && lane_sel == 2'd3) |=> (result == $past(opnd_a + opnd_b)));

    a_r5_single_lane_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel == 2'd3) |=> (((lane_carry >> 1) == '0) && ((lane_ovf >> 1) == '0)));

    a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_zero == (result == '0)));

    a_r8_carry_summary: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_carry == (|lane_carry)));

    a_r8_ovf_summary: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_ovf == (|lane_ovf)));

    a_r9_logic_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel >= 3'd2) |=> (lane_carry == '0 && lane_ovf == '0));
endmodule

bind simd_addsub simd_addsub_chk #(.DW(DW), .NS(NS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .op_sel     (op_sel),
    .lane_sel   (lane_sel),
    .out_valid  (out_valid),
    .result     (result),
    .lane_carry (lane_carry),
    .lane_ovf   (lane_ovf),
    .flag_zero  (flag_zero),
    .flag_ovf   (flag_ovf),
    .flag_carry (flag_carry)
);

// File: tb/simd_addsub_tb.sv
`timescale 1ns/1ps
// Directed bench for the partitioned SIMD adder-subtractor.
module simd_addsub_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  lane_sel = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [7:0]  lane_carry;
    logic [7:0]  lane_ovf;
    logic        flag_zero;
    logic        flag_ovf;
    logic        flag_carry;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    simd_addsub u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .lane_sel(lane_sel),
        .out_valid(out_valid), .result(result), .lane_carry(lane_carry),
        .lane_ovf(lane_ovf), .flag_zero(flag_zero), .flag_ovf(flag_ovf),
        .flag_carry(flag_carry)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference computed from the requirements, lane by lane.
    task automatic model(input logic [2:0] op, input logic [1:0] ls,
                         input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] r, output logic [7:0] c, output logic [7:0] v);
        r = '0; c = '0; v = '0;
        if (op <= 3'd1) begin
            int w = 8 << ls;
            int n = 64 / w;
            for (int k = 0; k < n; k++) begin
                logic [64:0] msk, al, bl, s;
                msk = (65'd1 << w) - 65'd1;
                al  = ({1'b0, a} >> (k * w)) & msk;
                bl  = ({1'b0, b} >> (k * w)) & msk;
                if (op == 3'd1) bl = (~bl) & msk;
                s = al + bl + {64'd0, op[0]};
                c[k] = s[w];
                v[k] = (al[w-1] == bl[w-1]) && (s[w-1] != al[w-1]);
                r = r | ((s[63:0] & msk[63:0]) << (k * w));
            end
        end else begin
            case (op)
                3'd2:    r = a & b;
                3'd3:    r = a | b;
                3'd4:    r = a ^ b;
                3'd5:    r = a & ~b;
                default: r = '0;
            endcase
            if (ls != 2'd3) r[63:32] = '0;
        end
    endtask

    // Accept one operation and check every output one edge later.
    task automatic run_op(input string tag, input logic [2:0] op, input logic [1:0] ls,
                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] er;
        logic [7:0]  ec, ev;
        model(op, ls, a, b, er, ec, ev);
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sel = op; lane_sel = ls; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R1 out_valid"}, {63'd0, out_valid}, 64'd1);
        check({tag, " result"}, result, er);
        check({tag, " R5 lane_carry"}, {56'd0, lane_carry}, {56'd0, ec});
        check({tag, " R6 lane_ovf"}, {56'd0, lane_ovf}, {56'd0, ev});
        check({tag, " R7 zero"}, {63'd0, flag_zero}, {63'd0, er == 64'd0});
        check({tag, " R8 carry"}, {63'd0, flag_carry}, {63'd0, |ec});
        check({tag, " R8 ovf"}, {63'd0, flag_ovf}, {63'd0, |ev});
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10 out_valid", {63'd0, out_valid}, 64'd0);
        check("R10 result", result, 64'd0);
        check("R10 flags", {58'd0, flag_zero, flag_ovf, flag_carry, 3'd0}, 64'd0);
        check("R10 lanes", {48'd0, lane_carry, lane_ovf}, 64'd0);
    endtask

    task automatic t_add_lanes;
        // R3: all-ones bytes next to boundaries; carries must not leak.
        run_op("R3 add8", 3'd0, 2'd0, 64'hFF80_7F01_FFFF_00FF, 64'h0180_0101_0001_0001);
        run_op("R3 add16", 3'd0, 2'd1, 64'hFFFF_7FFF_00FF_8000, 64'h0001_0001_0001_8000);
        run_op("R6 add32", 3'd0, 2'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001);
        run_op("R3 add64", 3'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);
        run_op("R3 add8iso", 3'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);
    endtask

    task automatic t_sub_lanes;
        // R4: equal lanes, borrows, signed overflow.
        run_op("R4 sub8", 3'd1, 2'd0, 64'h0010_8000_7F55_0102, 64'h0110_0180_FF55_0201);
        run_op("R4 sub16", 3'd1, 2'd1, 64'h1234_0000_8000_7FFF, 64'h1234_0001_0001_FFFF);
        run_op("R4 sub32", 3'd1, 2'd2, 64'h0000_0000_8000_0000, 64'h0000_0001_0000_0001);
        run_op("R4 sub64eq", 3'd1, 2'd3, 64'hDEAD_BEEF_0123_4567, 64'hDEAD_BEEF_0123_4567);
    endtask

    task automatic t_logic;
        logic [63:0] x, y;
        x = 64'hF0F0_AAAA_1234_FFFF;
        y = 64'h0FF0_5555_FF00_0F0F;
        for (int op = 2; op <= 7; op++) begin
            run_op("R9 logic64", 3'(op), 2'd3, x, y);
            run_op("R9 logic32", 3'(op), 2'd1, x, y);
        end
    endtask

    task automatic t_hold;
        logic [63:0] held;
        run_op("R2 prime", 3'd0, 2'd2, 64'h0000_0005_0000_0007, 64'h0000_0003_FFFF_FFFF);
        held = result;
        @(negedge clk);
        opnd_a = 64'hFFFF_FFFF_FFFF_FFFF; opnd_b = 64'h1; op_sel = 3'd0; lane_sel = 2'd3;
        repeat (3) @(negedge clk);
        check("R2 result held", result, held);
        check("R2 lane_carry held", {56'd0, lane_carry}, 64'h01);
        check("R1 out_valid low", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_random;
        for (int i = 0; i < 80; i++) begin
            logic [63:0] a, b;
            logic [2:0]  op;
            a  = {$urandom, $urandom};
            b  = {$urandom, $urandom};
            op = ($urandom % 3 == 0) ? 3'($urandom % 8) : 3'($urandom % 2);
            if (i % 5 == 0) b = a;
            run_op("R3 R4 mix", op, 2'($urandom % 4), a, b);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add_lanes();
        t_sub_lanes();
        t_logic();
        t_hold();
        t_random();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule